// File: doc/BRIEF.md
# Run-Length Expanding FIFO Read Port

This block sits between the head of a tagged byte FIFO and the host's read paths. Each FIFO entry carries an 8-bit byte plus one tag bit, and the FIFO shows its oldest entry at the head at all times. The block has three read paths: the main data address, the alternate data address and a DMA acknowledge strobe. Every accepted read returns the head byte one cycle later and tells the FIFO when to advance its read pointer.

When the transfer direction is peripheral-to-host, the block expands run-length encoded data. A head entry with a zero tag and a zero top data bit is a length marker. The block removes that marker from the FIFO on its own and never returns it to the host. It loads the low seven bits into a repeat counter. The following byte is then returned on count+1 host reads, and only the last of those reads advances the FIFO. In the other direction every read simply pops the head entry.

A mode change or FIFO reset is signalled on `flush`, which drops any loaded run. The block performs no compression on the send side and reports this on a constant capability output.

Top module: `rle_rd_port`

## Requirements
- R1: While reset is applied and afterwards until the first read, `rd_valid` and `head_pop` are 0, and `host_empty` follows `head_empty`.
- R2: With `dir_in` = 1 and no run loaded, an accepted read of a non-marker head entry returns that byte and pops exactly one entry.
- R3: A head entry is a length marker only when `head_tag` = 0 and `head_data[7]` = 0. With `dir_in` = 1 it is popped without any host read and is never returned; `head_data[6:0]` becomes the repeat count. An entry with tag 1, or with bit 7 set, is ordinary data.
- R4: After a marker with count N, the next entry is returned on N+1 accepted reads. Only the last of these reads pops it. A count of 0 gives a single read.
- R5: Reads on `host_rd_main`, `host_rd_alt` and `host_rd_dma` are treated alike, including for expansion. At most one of the three is high in any cycle.
- R6: With `dir_in` = 0 nothing is expanded: every accepted read pops the head, marker-shaped entries included.
- R7: If the FIFO is empty after a marker has been taken, `host_empty` stays 1. The loaded count is kept until the data entry arrives.
- R8: While a run is loaded and its data entry is present, `host_empty` is 0, even when that entry is the only one left in the FIFO.
- R9: A one-cycle `flush` clears any loaded run. After it, the head entry is treated as new (one read, one pop), and a read in the flush cycle is ignored.
- R10: A read while `host_empty` = 1 is ignored: no `rd_valid` and no pop.
- R11: `comp_cap` is constantly 0, which reports that no compression is offered on the send side.
- R12: `rd_valid` rises exactly one cycle after an accepted read, and `rd_data` then holds the head byte seen in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_in | input | 1 | 1 = peripheral-to-host, which enables expansion |
| flush | input | 1 | Mode change or FIFO reset; clears the run state |
| head_empty | input | 1 | FIFO holds no entry |
| head_data | input | 8 | Data byte of the FIFO head entry |
| head_tag | input | 1 | Tag bit of the FIFO head entry |
| host_rd_main | input | 1 | Host read strobe, main data address |
| host_rd_alt | input | 1 | Host read strobe, alternate data address |
| host_rd_dma | input | 1 | DMA read strobe |
| head_pop | output | 1 | Advance the FIFO read pointer this cycle |
| host_empty | output | 1 | No byte is available to the host |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 8 | Read data returned to the host |
| comp_cap | output | 1 | Send-side compression capability, always 0 |

## Verification
The checker assumes that at most one read strobe is high per cycle and that the FIFO head stays stable between pops. It also assumes that `dir_in` changes only together with a `flush`. The bench models the FIFO as an array whose pointer advances only on `head_pop`. It drives a single strobe per read, and switches direction only while idle with the FIFO drained. Reads are issued only once `host_empty` is low, except in the one test where a read on empty is deliberate.

// File: rtl/rle_rd_pkg.sv
package rle_rd_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_N_SRC  = 3;

  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_LOAD = 1'b1
  } run_state_e;
endpackage

// File: rtl/rle_src_merge.sv
module rle_src_merge #(
  parameter int unsigned N_SRC = 3
) (
  input  logic [N_SRC-1:0] req,
  output logic             any_req
);
  logic [N_SRC:0] acc;

  assign acc[0] = 1'b0;
  for (genvar g = 0; g < N_SRC; g++) begin : g_or
    assign acc[g+1] = acc[g] | req[g];
  end

  assign any_req = acc[N_SRC];
endmodule

// File: rtl/rle_len_detect.sv
module rle_len_detect #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = DATA_W - 1
) (
  input  logic              dir_in,
  input  logic              present,
  input  logic [DATA_W-1:0] data,
  input  logic              tag,
  output logic              is_marker,
  output logic [CNT_W-1:0]  count
);
  assign is_marker = dir_in & present & ~tag & ~data[DATA_W-1];
  assign count     = data[CNT_W-1:0];
endmodule

// File: rtl/rle_run_ctr.sv
module rle_run_ctr
  import rle_rd_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             active,
  output logic             last
);
  run_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (clr) begin
      st_d  = RUN_IDLE;
      cnt_d = '0;
    end else if (load) begin
      st_d  = RUN_LOAD;
      cnt_d = load_val;
    end else if (step && st_q == RUN_LOAD) begin
      if (cnt_q == '0) begin
        st_d = RUN_IDLE;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RUN_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = (st_q == RUN_LOAD);
  assign last   = (cnt_q == '0);
endmodule

// File: rtl/rle_rd_port.sv
module rle_rd_port
  import rle_rd_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned N_SRC  = DEF_N_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_in,
  input  logic              flush,
  input  logic              head_empty,
  input  logic [DATA_W-1:0] head_data,
  input  logic              head_tag,
  input  logic              host_rd_main,
  input  logic              host_rd_alt,
  input  logic              host_rd_dma,
  output logic              head_pop,
  output logic              host_empty,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              comp_cap
);
  localparam int unsigned CNT_W = DATA_W - 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // merge the read paths
  logic [N_SRC-1:0] rd_vec;
  logic             rd_any;

  if (N_SRC >= 3) begin : g_three
    assign rd_vec = {{(N_SRC-3){1'b0}}, host_rd_dma, host_rd_alt, host_rd_main};
  end else begin : g_bad
    assign rd_vec = '0;
  end

  rle_src_merge #(.N_SRC(N_SRC)) u_merge (
    .req     (rd_vec),
    .any_req (rd_any)
  );

  // classify the head entry
  logic             hd_marker;
  logic [CNT_W-1:0] hd_count;

  rle_len_detect #(.DATA_W(DATA_W)) u_detect (
    .dir_in    (dir_in),
    .present   (~head_empty),
    .data      (head_data),
    .tag       (head_tag),
    .is_marker (hd_marker),
    .count     (hd_count)
  );

  // run counter
  logic run_active, run_last;
  logic auto_take, rd_ok, rd_step, rd_pop;

  rle_run_ctr #(.CNT_W(CNT_W)) u_run (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (flush),
    .load     (auto_take),
    .load_val (hd_count),
    .step     (rd_step),
    .active   (run_active),
    .last     (run_last)
  );

  // next-state logic
  always_comb begin
    host_empty = head_empty | (~run_active & hd_marker);
    auto_take  = hd_marker & ~run_active & ~flush & rst_int_n;
    rd_ok      = rd_any & ~host_empty & ~flush & rst_int_n;
    rd_step    = rd_ok & run_active;
    rd_pop     = rd_ok & (~run_active | run_last);
    head_pop   = auto_take | rd_pop;
  end

  // output registers
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      data_q <= '0;
    end else if (rd_ok) begin
      data_q <= head_data;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;
  assign comp_cap = 1'b0;
endmodule

// File: rtl/rle_rd_port_chk.sv
module rle_rd_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_in,
  input logic              flush,
  input logic              head_empty,
  input logic [DATA_W-1:0] head_data,
  input logic              host_rd_main,
  input logic              host_rd_alt,
  input logic              host_rd_dma,
  input logic              head_pop,
  input logic              host_empty,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              run_active
);
  logic any_rd;
  assign any_rd = host_rd_main | host_rd_alt | host_rd_dma;

  // R5
  one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_rd_main, host_rd_alt, host_rd_dma}));

  // R10
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_empty |-> !head_pop);

  // R12
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(any_rd && !host_empty && !flush));

  // R12
  data_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data == $past(head_data));

  // R6
  out_dir_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_in && !run_active && !flush && !head_empty && any_rd && rd_valid === rd_valid)
      |=> (rd_valid || !rst_n));

  // R9
  flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !run_active);

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && head_empty) |-> host_empty);

  // R8
  run_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && !head_empty) |-> !host_empty);
endmodule

bind rle_rd_port rle_rd_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dir_in       (dir_in),
  .flush        (flush),
  .head_empty   (head_empty),
  .head_data    (head_data),
  .host_rd_main (host_rd_main),
  .host_rd_alt  (host_rd_alt),
  .host_rd_dma  (host_rd_dma),
  .head_pop     (head_pop),
  .host_empty   (host_empty),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data),
  .run_active   (run_active)
);

// File: tb/test_rle_rd_port.sv
module test_rle_rd_port;
  logic       clk;
  logic       rst_n;
  logic       dir_in;
  logic       flush;
  logic       host_rd_main, host_rd_alt, host_rd_dma;
  logic       head_pop, host_empty, rd_valid, comp_cap;
  logic [7:0] rd_data;
  logic       head_empty;
  logic [7:0] head_data;
  logic       head_tag;

  // FIFO model: {tag, data}
  logic [8:0] mem [0:63];
  int         wp;
  int         rp;

  assign head_empty = (wp == rp);
  assign head_data  = mem[rp % 64][7:0];
  assign head_tag   = mem[rp % 64][8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rp <= 0;
    else if (head_pop) rp <= rp + 1;
  end

  int         checks;
  int         errors;
  logic [7:0] expq [$];

  rle_rd_port i_rle_rd_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .dir_in       (dir_in),
    .flush        (flush),
    .head_empty   (head_empty),
    .head_data    (head_data),
    .head_tag     (head_tag),
    .host_rd_main (host_rd_main),
    .host_rd_alt  (host_rd_alt),
    .host_rd_dma  (host_rd_dma),
    .head_pop     (head_pop),
    .host_empty   (host_empty),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .comp_cap     (comp_cap)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic tag, input logic [7:0] data);
    mem[wp % 64] = {tag, data};
    wp++;
  endtask

  // driver: waits for data, issues one read, posts the expected byte
  task automatic rd(input int src, input logic [7:0] exp);
    while (host_empty) @(negedge clk);
    expq.push_back(exp);
    case (src)
      0: host_rd_main = 1'b1;
      1: host_rd_alt  = 1'b1;
      default: host_rd_dma = 1'b1;
    endcase
    @(negedge clk);
    host_rd_main = 1'b0;
    host_rd_alt  = 1'b0;
    host_rd_dma  = 1'b0;
  endtask

  // monitor: scoreboard compare (R12 timing)
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R12 unexpected rd_valid", rd_data, 0);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(rd_data == e, "R12 rd_data", rd_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; wp = 0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    rst_n = 1'b0; dir_in = 1'b1; flush = 1'b0;
    host_rd_main = 1'b0; host_rd_alt = 1'b0; host_rd_dma = 1'b0;
    repeat (3) @(negedge clk);
    // R1, R11
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(head_pop == 1'b0, "R1 head_pop", head_pop, 0);
    chk(host_empty == 1'b1, "R1 host_empty", host_empty, 1);
    chk(comp_cap == 1'b0, "R11 comp_cap", comp_cap, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rd_valid == 1'b0, "R1 rd_valid after release", rd_valid, 0);

    // R2: plain bytes
    push(1'b1, 8'h11); push(1'b1, 8'h22); push(1'b1, 8'h33);
    rd(0, 8'h11); rd(0, 8'h22); rd(0, 8'h33);
    @(negedge clk);
    chk(wp == rp, "R2 one pop per read", rp, wp);

    // R3, R4, R8: marker count 3
    push(1'b0, 8'h03); push(1'b1, 8'hA5);
    rd(0, 8'hA5); rd(0, 8'hA5); rd(0, 8'hA5);
    chk(wp - rp == 1, "R4 data held", wp - rp, 1);
    chk(host_empty == 1'b0, "R8 not empty during run", host_empty, 0);
    rd(0, 8'hA5);
    @(negedge clk);
    chk(wp == rp, "R4 pop on last repeat", rp, wp);

    // R3: bit7 set with tag 0, and tag 1 with bit7 clear are data
    push(1'b0, 8'h85); push(1'b1, 8'h05);
    rd(0, 8'h85); rd(0, 8'h05);
    @(negedge clk);
    chk(wp == rp, "R3 non-markers pop once", rp, wp);

    // R4: count 0
    push(1'b0, 8'h00); push(1'b1, 8'h77); push(1'b1, 8'h78);
    rd(0, 8'h77);
    @(negedge clk);
    chk(wp - rp == 1, "R4 count zero single read", wp - rp, 1);
    rd(0, 8'h78);

    // R5: all paths expand
    push(1'b0, 8'h02); push(1'b1, 8'hC3);
    rd(1, 8'hC3); rd(2, 8'hC3); rd(0, 8'hC3);
    @(negedge clk);
    chk(wp == rp, "R5 paths share run", rp, wp);

    // R7: marker with no data yet
    push(1'b0, 8'h01);
    repeat (3) @(negedge clk);
    chk(wp == rp, "R3 marker taken silently", rp, wp);
    chk(host_empty == 1'b1, "R7 empty while waiting", host_empty, 1);
    push(1'b1, 8'h9A);
    rd(2, 8'h9A); rd(2, 8'h9A);
    @(negedge clk);
    chk(wp == rp, "R7 count kept", rp, wp);

    // R10: read on empty ignored
    host_rd_main = 1'b1;
    @(negedge clk);
    host_rd_main = 1'b0;
    chk(head_pop == 1'b0, "R10 no pop", head_pop, 0);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R10 no rd_valid", rd_valid, 0);

    // R9: flush mid-run
    push(1'b0, 8'h05); push(1'b1, 8'h4E); push(1'b1, 8'h12);
    rd(0, 8'h4E); rd(0, 8'h4E);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    rd(0, 8'h4E);
    @(negedge clk);
    chk(wp - rp == 1, "R9 run cleared", wp - rp, 1);
    rd(0, 8'h12);

    // R6: output direction, no expansion
    @(negedge clk);
    flush = 1'b1; dir_in = 1'b0;
    @(negedge clk);
    flush = 1'b0;
    push(1'b0, 8'h02); push(1'b1, 8'h66);
    @(negedge clk);
    chk(wp - rp == 2, "R6 marker not taken", wp - rp, 2);
    rd(0, 8'h02); rd(0, 8'h66);
    @(negedge clk);
    chk(wp == rp, "R6 each read pops", rp, wp);

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R12 all reads answered", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule